// File: doc/BRIEF.md
# Field-Programmable Sum-of-Products Array

This block is a programmable logic array that evaluates eight Boolean functions of a sixteen-bit input word. Its personality is held in configuration registers and has two planes. In the first plane, each of 48 product terms is the AND of literals chosen per input. Each literal is the true input, its complement, or nothing. In the second plane, each output ORs any subset of those terms and can then invert the result. Several outputs may share the same term.

The configuration registers are loaded through a one-word-per-cycle address/data port. A write is committed on the clock edge that samples it. The evaluation path from `in_vec` to the outputs holds no registers, so outputs follow the inputs within the same cycle.

A chip-enable input gates the output drivers. The `DRIVE` parameter picks three-state or open-collector behaviour. Both modes are expressed as a per-output drive value and drive enable, and no tri-state net exists inside the block.

Top module: `sop_array`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first write, every AND word holds all ones, every OR word holds zero, and every output function is 0.
- R2: In the AND word of term t (address t, 0..47), bit 2i set requires input i to be 1 and bit 2i+1 set requires input i to be 0. With both bits set, term t is forced to 0.
- R3: An input whose two AND-word bits are both clear does not affect the term. A term whose word is all zero evaluates to 1.
- R4: In the OR word of output k (address 48+k), bits [47:0] select the terms ORed into output k, and a term may feed several outputs. An output with no selected term yields 0 before inversion.
- R5: Bit 48 of the OR word of output k inverts that output's function.
- R6: A word is written only when `cfg_we` is high on a rising clock edge. Addresses 56 to 63 change nothing, and `cfg_data` bits above bit 31 are unused for AND words.
- R7: Outputs respond to `in_vec` and `chip_en` combinationally, without waiting for a clock edge.
- R8: In three-state mode, `out_en` is all ones and `out_val` equals the functions while `chip_en` is high. `out_en` and `out_val` are all zero while `chip_en` is low.
- R9: In open-collector mode, `out_val` is always 0 and `out_en[k]` is high exactly when `chip_en` is high and function k is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset of the personality |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Word address: 0..47 AND words, 48..55 OR words |
| cfg_data | input | 49 | Configuration word to write |
| chip_en | input | 1 | Output driver enable, active high |
| in_vec | input | 16 | Array inputs |
| out_val | output | 8 | Per-output drive value |
| out_en | output | 8 | Per-output drive enable (0 means high impedance) |

## Verification
Outputs are due zero cycles after an input or chip-enable change. The bench therefore compares them one nanosecond after it drives the inputs, before any clock edge intervenes. A configuration write is due one edge later, so the reference model applies each write only after the rising edge that commits it. A second comparison is made just after that edge on every clock. Both the three-state and the open-collector instance are compared against the same model in every cycle.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic {
        DRV_TRISTATE,
        DRV_OPEN_COLLECTOR
    } drive_mode_e;

    function automatic int unsigned cfg_width(int unsigned n_in, int unsigned n_term);
        return (2 * n_in > n_term + 1) ? 2 * n_in : n_term + 1;
    endfunction

endpackage

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int unsigned N_IN   = 16,
    parameter int unsigned N_TERM = 48,
    parameter int unsigned AW     = 6,
    localparam int unsigned LW    = 2 * N_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [LW-1:0]     cfg_word,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_TERM-1:0] term_o
);

    logic [LW-1:0] lit_q [N_TERM];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERM; t++) lit_q[t] <= '1;
        end else if (cfg_we) begin
            for (int t = 0; t < N_TERM; t++)
                if (cfg_addr == AW'(t)) lit_q[t] <= cfg_word;
        end
    end

    always_comb begin
        for (int t = 0; t < N_TERM; t++) begin
            term_o[t] = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                if (lit_q[t][2*i]   && !in_vec[i]) term_o[t] = 1'b0;
                if (lit_q[t][2*i+1] &&  in_vec[i]) term_o[t] = 1'b0;
            end
        end
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_chk
        // R3
        all_dont_care_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lit_q[t] == '0) |-> term_o[t]);
        // R2
        both_literals_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lit_q[t][1:0] == 2'b11) |-> !term_o[t]);
        // R6
        hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_addr == AW'(t)) |=> $stable(lit_q[t]));
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int unsigned N_TERM = 48,
    parameter int unsigned N_OUT  = 8,
    parameter int unsigned AW     = 6,
    localparam int unsigned OW    = N_TERM + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [OW-1:0]     cfg_word,
    input  logic [N_TERM-1:0] term_i,
    output logic [N_OUT-1:0]  func_o
);

    logic [OW-1:0] sel_q [N_OUT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_OUT; k++) sel_q[k] <= '0;
        end else if (cfg_we) begin
            for (int k = 0; k < N_OUT; k++)
                if (cfg_addr == AW'(N_TERM + k)) sel_q[k] <= cfg_word;
        end
    end

    always_comb begin
        for (int k = 0; k < N_OUT; k++)
            func_o[k] = (|(sel_q[k][N_TERM-1:0] & term_i)) ^ sel_q[k][N_TERM];
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_chk
        // R4
        empty_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q[k][N_TERM-1:0] == '0) |-> (func_o[k] == sel_q[k][N_TERM]));
        // R6
        hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_addr == AW'(N_TERM + k)) |=> $stable(sel_q[k]));
    end

endmodule

// File: rtl/sop_drive.sv
module sop_drive #(
    parameter int unsigned         N_OUT = 8,
    parameter sop_pkg::drive_mode_e MODE = sop_pkg::DRV_TRISTATE
) (
    input  logic             chip_en,
    input  logic [N_OUT-1:0] func_i,
    output logic [N_OUT-1:0] drv_val,
    output logic [N_OUT-1:0] drv_en
);

    if (MODE == sop_pkg::DRV_TRISTATE) begin : g_tri
        always_comb begin
            drv_en  = {N_OUT{chip_en}};
            drv_val = chip_en ? func_i : '0;
        end
    end else begin : g_oc
        always_comb begin
            drv_val = '0;
            drv_en  = chip_en ? ~func_i : '0;
        end
        always_comb begin
            // R9
            never_drive_high_chk: assert ((drv_val & drv_en) == '0);
        end
    end

    always_comb begin
        // R8
        if (!chip_en) released_chk: assert (drv_en == '0);
    end

endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter int unsigned          N_IN   = 16,
    parameter int unsigned          N_TERM = 48,
    parameter int unsigned          N_OUT  = 8,
    parameter sop_pkg::drive_mode_e DRIVE  = sop_pkg::DRV_TRISTATE
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            cfg_we,
    input  logic [$clog2(N_TERM+N_OUT)-1:0]                 cfg_addr,
    input  logic [sop_pkg::cfg_width(N_IN, N_TERM)-1:0]     cfg_data,
    input  logic                                            chip_en,
    input  logic [N_IN-1:0]                                 in_vec,
    output logic [N_OUT-1:0]                                out_val,
    output logic [N_OUT-1:0]                                out_en
);

    localparam int unsigned AW = $clog2(N_TERM + N_OUT);
    localparam int unsigned LW = 2 * N_IN;
    localparam int unsigned OW = N_TERM + 1;

    logic [N_TERM-1:0] term;
    logic [N_OUT-1:0]  func;

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM), .AW(AW)) u_and (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_word (cfg_data[LW-1:0]),
        .in_vec   (in_vec),
        .term_o   (term)
    );

    sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW)) u_or (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_word (cfg_data[OW-1:0]),
        .term_i   (term),
        .func_o   (func)
    );

    sop_drive #(.N_OUT(N_OUT), .MODE(DRIVE)) u_drive (
        .chip_en (chip_en),
        .func_i  (func),
        .drv_val (out_val),
        .drv_en  (out_en)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (func == '0));

endmodule

// File: tb/sop_array_bench.sv
`timescale 1ns/1ps
module sop_array_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [48:0] cfg_data = '0;
    logic        chip_en = 1'b1;
    logic [15:0] in_vec = '0;
    logic [7:0]  ts_val, ts_en, oc_val, oc_en;

    int n_cmp = 0;
    int n_bad = 0;

    bit [31:0] m_and [48];
    bit [48:0] m_or  [8];

    always #2 clk = ~clk;

    sop_array u_sop_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .chip_en(chip_en), .in_vec(in_vec),
        .out_val(ts_val), .out_en(ts_en)
    );

    sop_array #(.DRIVE(sop_pkg::DRV_OPEN_COLLECTOR)) u_sop_array_oc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .chip_en(chip_en), .in_vec(in_vec),
        .out_val(oc_val), .out_en(oc_en)
    );

    function automatic bit [7:0] model_f(bit [15:0] x);
        bit [7:0] f;
        for (int k = 0; k < 8; k++) begin
            bit acc = 0;
            for (int t = 0; t < 48; t++) begin
                bit on = 1;
                if (!m_or[k][t]) continue;
                for (int i = 0; i < 16; i++) begin
                    if (m_and[t][2*i] && x[i] == 0) on = 0;
                    if (m_and[t][2*i+1] && x[i] == 1) on = 0;
                end
                if (on) acc = 1;
            end
            f[k] = acc ^ m_or[k][48];
        end
        return f;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < 48; t++) m_and[t] = '1;
        for (int k = 0; k < 8; k++) m_or[k] = '0;
    endtask

    task automatic compare(string tag);
        bit [7:0] f = model_f(in_vec);
        bit [7:0] e_ts_val = chip_en ? f : 8'h00;
        bit [7:0] e_ts_en  = chip_en ? 8'hFF : 8'h00;
        bit [7:0] e_oc_en  = chip_en ? ~f : 8'h00;
        n_cmp++;
        if (ts_val !== e_ts_val || ts_en !== e_ts_en || oc_val !== 8'h00 || oc_en !== e_oc_en) begin
            n_bad++;
            $display("FAIL %s in=%h ce=%b actual ts_val=%h ts_en=%h oc_val=%h oc_en=%h expected %h %h 00 %h",
                     tag, in_vec, chip_en, ts_val, ts_en, oc_val, oc_en, e_ts_val, e_ts_en, e_oc_en);
        end
    endtask

    // one clock: inputs change, same-cycle check (R7), then post-edge check
    task automatic cycle(bit [15:0] x, bit ce, string tag);
        @(negedge clk);
        in_vec  = x;
        chip_en = ce;
        #1 compare(tag);
        @(posedge clk);
        #1 compare(tag);
    endtask

    task automatic write_word(int addr, bit [48:0] data, bit we, string tag);
        @(negedge clk);
        cfg_we   = we;
        cfg_addr = 6'(addr);
        cfg_data = data;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (we) begin
            if (addr < 48) m_and[addr] = data[31:0];
            else if (addr < 56) m_or[addr-48] = data;
        end
        compare(tag);
    endtask

    function automatic bit [31:0] rand_and();
        bit [31:0] w = '0;
        for (int i = 0; i < 16; i++) begin
            int r = $urandom_range(0, 15);
            if (r == 0) w[2*i] = 1;
            else if (r == 1) w[2*i+1] = 1;
            else if (r == 2 && $urandom_range(0, 7) == 0) begin
                w[2*i] = 1; w[2*i+1] = 1;
            end
        end
        return w;
    endfunction

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        // R1: reset state, outputs 0 whatever the inputs
        for (int n = 0; n < 4; n++) cycle(16'($urandom), 1'b1, "R1");
        @(negedge clk) rst_n = 1'b1;
        cycle(16'hFFFF, 1'b1, "R1");
        cycle(16'h0000, 1'b1, "R1");

        // R2: term0 = in0 & ~in1 on output 0
        write_word(0, 49'h0_0000_0009, 1'b1, "R2");
        write_word(48, 49'h1, 1'b1, "R2");
        cycle(16'h0001, 1'b1, "R2");
        cycle(16'h0003, 1'b1, "R2");
        cycle(16'h0000, 1'b1, "R2");
        // R2: both literals of input 5 force term1 to 0 on output 1
        write_word(1, 49'h0_0000_0C00, 1'b1, "R2");
        write_word(49, 49'h2, 1'b1, "R2");
        cycle(16'h0020, 1'b1, "R2");
        cycle(16'h0000, 1'b1, "R2");

        // R3: term2 all don't-care gives 1; R4: output 3 empty, output 4 shares terms
        write_word(2, 49'h0, 1'b1, "R3");
        write_word(50, 49'h4, 1'b1, "R3");
        write_word(52, 49'h5, 1'b1, "R4");
        cycle(16'hA5A5, 1'b1, "R3");
        cycle(16'h0001, 1'b1, "R4");

        // R5: inverted empty sum on output 5, inverted term0 on output 6
        write_word(53, 49'h1_0000_0000_0000, 1'b1, "R5");
        write_word(54, 49'h1_0000_0000_0001, 1'b1, "R5");
        cycle(16'h0001, 1'b1, "R5");
        cycle(16'h0002, 1'b1, "R5");

        // R6: write with strobe low, and write to unmapped address 60
        write_word(2, '1, 1'b0, "R6");
        write_word(60, '1, 1'b1, "R6");
        write_word(63, '1, 1'b1, "R6");
        cycle(16'h1234, 1'b1, "R6");
        cycle(16'h0001, 1'b1, "R6");

        // R8/R9: chip enable low then high
        cycle(16'h0001, 1'b0, "R8/R9");
        cycle(16'hFFFF, 1'b0, "R8/R9");
        cycle(16'h0001, 1'b1, "R8/R9");

        // R7 with random personalities and inputs
        for (int p = 0; p < 20; p++) begin
            for (int t = 0; t < 48; t++) write_word(t, 49'(rand_and()), 1'b1, "R2");
            for (int k = 0; k < 8; k++)
                write_word(48 + k, {1'($urandom), 16'($urandom), 32'($urandom)}, 1'b1, "R4");
            for (int c = 0; c < 40; c++)
                cycle(16'($urandom), ($urandom_range(0, 5) != 0), "R7");
        end

        // R1: reset again restores the blank personality
        @(negedge clk) rst_n = 1'b0;
        model_reset();
        cycle(16'h0000, 1'b1, "R1");
        cycle(16'hFFFF, 1'b1, "R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule